// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received frames into memory buffers described by a circular ring of descriptors. Each descriptor has a 16-bit status/control word, a 16-bit length word and a buffer address. The engine reads the descriptor at the current ring index from an external descriptor memory. If software has marked the descriptor empty, the engine writes the bytes of the next frame into the buffer that the descriptor points to. It then writes back a status word and the received length, and moves on to the next descriptor. A descriptor whose wrap flag is set sends the engine back to index 0.

Software owns a descriptor while its empty flag is clear. To hand a descriptor back, software sets the empty flag and pulses `cont`. When the engine meets a descriptor that is not empty, it stalls there and fetches nothing more. Frames that begin while no descriptor is ready are discarded whole, and a sticky drop flag records that this happened. A `kill` pulse, like reset, idles the engine and returns the ring index to 0. It never writes to a descriptor. After a kill, the next `cont` restarts the engine at index 0.

The descriptor memory returns read data one cycle after `dsc_rd_en`. Frame bytes arrive one per cycle on a valid/last stream. A frame's error flags are valid together with its last byte. Between the last byte of one frame and the first byte of the next there must be at least three idle cycles.

Top module: `rxr_ring_engine`

## Requirements
- R1: After reset the engine issues no descriptor read and no buffer or descriptor write until a `cont` pulse arrives, and `rx_dropped` is 0.
- R2: Only a fetched descriptor whose status bit 15 (empty) is set receives a frame. Byte k of the frame is written to address `dsc_rd_addr + k`, in stream order, one byte per write.
- R3: After writing back a descriptor whose status bit 14 (wrap) was set, the next descriptor fetched is index 0. Otherwise the next fetch is the previous index plus one.
- R4: The write-back word puts the status on `dsc_wr_data[31:16]` and the length on `[15:0]`. The status has bit 15 (empty) cleared and bit 13 (last) set. Bits 4:0 carry the error flags. Every other bit, wrap included, keeps its fetched value.
- R5: `rx_err[3:0]`, sampled with the last byte, is written to status bits 3:0: bit 3 non-octet-aligned, bit 2 CRC error, bit 1 receive FIFO overrun, bit 0 truncated.
- R6: The written length counts every byte the stream delivers for the frame, the 4 trailing frame check sequence bytes included.
- R7: A frame longer than MAX_FRAME (1518) bytes has only its first 1518 bytes written. Its written length is 1518 and status bit 4 (too long) is set. A frame of exactly 1518 bytes leaves bit 4 clear.
- R8: On a descriptor that is not empty the engine stalls and fetches nothing more until `cont`. After `cont` it fetches the same index again.
- R9: A frame whose first byte arrives while no empty descriptor is ready is dropped entirely: no buffer or descriptor write. `rx_dropped` is set and stays set.
- R10: `kill` returns the ring index to 0, idles the engine and clears `rx_dropped`, without writing any descriptor. The next `cont` fetches index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| kill | input | 1 | Stop pulse: idle the engine, ring index to 0 |
| cont | input | 1 | Start/continue pulse: re-check the current descriptor |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_err | input | 4 | Frame error flags, valid with rx_last |
| dsc_rd_en | output | 1 | Descriptor read request |
| dsc_wr_en | output | 1 | Descriptor status/length write |
| dsc_idx | output | IDX_W (4) | Descriptor index for read or write |
| dsc_rd_stat | input | 16 | Status word of the descriptor read, one cycle after request |
| dsc_rd_addr | input | ADDR_W (32) | Buffer address of the descriptor read, one cycle after request |
| dsc_wr_data | output | 32 | Status (31:16) and length (15:0) to write back |
| buf_wr_en | output | 1 | Buffer byte write |
| buf_wr_addr | output | ADDR_W (32) | Buffer byte address |
| buf_wr_data | output | 8 | Buffer byte |
| rx_dropped | output | 1 | Sticky: a frame was discarded |

## Verification
The ring is fed frames of 1, 20, 40, 60, 64 and 100 bytes, each with a different error pattern. This tells apart correct placement of the payload, the error-bit mapping, and the carrying through of software-owned status bits. Filling the ring up to the wrap descriptor and sending one more frame separates wrap handling from a plain stall and a drop. Frames of 1518 and 1520 bytes bracket the too-long limit. A kill followed by a frame while the engine is idle, then a restart, shows the index returning to 0 and the descriptor memory left untouched.

// File: rtl/rxr_pkg.sv
// Package: shared constants and types of the receive descriptor ring engine.
// Assumes 16-bit descriptor status and length words.
package rxr_pkg;
    localparam int ST_EMPTY = 15;   // descriptor owned by the engine
    localparam int ST_WRAP  = 14;   // last descriptor of the ring
    localparam int ST_LAST  = 13;   // descriptor ends a frame
    localparam int ST_LONG  = 4;    // frame exceeded the size limit
    localparam int ERR_W    = 4;    // stream error flags on status bits 3:0
    localparam int HALF_W   = 16;
    // bits rewritten at write-back: empty, last and the five error bits
    localparam logic [HALF_W-1:0] ST_CLR_MASK = 16'hA01F;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_FETCH,
        RX_CHECK,
        RX_STALL,
        RX_READY,
        RX_WBACK
    } rxr_state_e;
endpackage

// File: rtl/rxr_ring_ptr.sv
// Module: ring index of the current descriptor.
// Steps by one after each write-back, or returns to 0 when the written-back
// descriptor carried the wrap flag. Reset and kill force index 0.
module rxr_ring_ptr #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic             advance,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);
    // Purpose: hold and step the ring index.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            idx <= '0;
        end else if (advance) begin
            idx <= wrap ? '0 : idx + IDX_W'(1);
        end
    end

    // R10
    kill_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> idx == '0);
    // R3
    wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && wrap && !kill) |=> idx == '0);
    // R3
    step_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !wrap && !kill) |=> idx == IDX_W'($past(idx) + IDX_W'(1)));
endmodule

// File: rtl/rxr_ctrl.sv
// Module: descriptor sequencing state machine.
// Fetches a descriptor, waits one cycle for the read data, then either
// accepts a frame (empty descriptor) or stalls until cont. After a frame
// it writes the descriptor back and fetches the next one.
// Assumes the descriptor memory answers one cycle after the read request.
module rxr_ctrl
    import rxr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kill,
    input  logic       cont,
    input  logic       desc_empty,
    input  logic       frame_done,
    output rxr_state_e state
);
    rxr_state_e state_nx;

    // Purpose: choose the next state; kill overrides everything.
    always_comb begin
        state_nx = state;
        if (kill) begin
            state_nx = RX_IDLE;
        end else begin
            unique case (state)
                RX_IDLE:  if (cont) state_nx = RX_FETCH;
                RX_FETCH: state_nx = RX_CHECK;
                RX_CHECK: state_nx = desc_empty ? RX_READY : RX_STALL;
                RX_STALL: if (cont) state_nx = RX_FETCH;
                RX_READY: if (frame_done) state_nx = RX_WBACK;
                RX_WBACK: state_nx = RX_FETCH;
                default:  state_nx = RX_IDLE;
            endcase
        end
    end

    // Purpose: state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // R1
    idle_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && !cont) |=> state == RX_IDLE);
    // R2
    nonempty_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_CHECK && !desc_empty && !kill) |=> state == RX_STALL);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_STALL && !cont && !kill) |=> state == RX_STALL);
    // R10
    kill_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> state == RX_IDLE);
endmodule

// File: rtl/rxr_frame_path.sv
// Module: frame byte path.
// Latches the fetched descriptor, decides per frame whether it is taken
// (first byte seen while ready) or dropped, writes taken bytes to the
// buffer through a registered byte port, counts the length with saturation
// above MAX_FRAME, and builds the write-back status/length word.
// Assumes error flags are valid with the last byte and that frames are
// separated by at least three idle cycles.
module rxr_frame_path
    import rxr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 1518
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                kill,
    input  logic                ready,
    input  logic                load_desc,
    input  logic [HALF_W-1:0]   desc_stat,
    input  logic [ADDR_W-1:0]   desc_base,
    input  logic                rx_valid,
    input  logic [7:0]          rx_data,
    input  logic                rx_last,
    input  logic [ERR_W-1:0]    rx_err,
    output logic                frame_done,
    output logic                desc_wrap,
    output logic [2*HALF_W-1:0] wb_word,
    output logic                buf_wr_en,
    output logic [ADDR_W-1:0]   buf_wr_addr,
    output logic [7:0]          buf_wr_data,
    output logic                dropped
);
    localparam int CW = $clog2(MAX_FRAME + 2);
    localparam logic [CW-1:0] CNT_MAX = CW'(MAX_FRAME);

    logic                in_frame;
    logic                taking;
    logic                take;
    logic                start;
    logic                too_long;
    logic [CW-1:0]       cnt;
    logic [CW-1:0]       cnt_base;
    logic [CW-1:0]       cnt_inc;
    logic [HALF_W-1:0]   stat_q;
    logic [HALF_W-1:0]   new_stat;
    logic [HALF_W-1:0]   len_out;
    logic [ADDR_W-1:0]   base_q;

    // Purpose: byte acceptance, saturating length and write-back status.
    always_comb begin
        start    = !in_frame;
        take     = rx_valid && !kill && (taking || (start && ready));
        cnt_base = start ? '0 : cnt;
        cnt_inc  = (cnt_base > CNT_MAX) ? cnt_base : cnt_base + CW'(1);
        too_long = cnt_inc > CNT_MAX;
        len_out  = too_long ? HALF_W'(MAX_FRAME) : HALF_W'(cnt_inc);
        new_stat = (stat_q & ~ST_CLR_MASK) | (HALF_W'(1) << ST_LAST)
                 | {{(HALF_W-ERR_W-1){1'b0}}, too_long, rx_err};
    end

    assign frame_done = take && rx_last;
    assign desc_wrap  = stat_q[ST_WRAP];

    // Purpose: track frame boundaries on the stream, taken or not.
    always_ff @(posedge clk) begin
        if (!rst_n)        in_frame <= 1'b0;
        else if (rx_valid) in_frame <= !rx_last;
    end

    // Purpose: remember that the frame in flight is being stored.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            taking <= 1'b0;
            cnt    <= '0;
        end else if (take) begin
            taking <= !rx_last;
            cnt    <= cnt_inc;
        end
    end

    // Purpose: hold the descriptor fetched in the check cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            base_q <= '0;
        end else if (load_desc) begin
            stat_q <= desc_stat;
            base_q <= desc_base;
        end
    end

    // Purpose: registered buffer byte write, limited to MAX_FRAME bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_wr_en   <= 1'b0;
            buf_wr_addr <= '0;
            buf_wr_data <= '0;
        end else begin
            buf_wr_en   <= take && (cnt_base < CNT_MAX);
            buf_wr_addr <= base_q + ADDR_W'(cnt_base);
            buf_wr_data <= rx_data;
        end
    end

    // Purpose: capture the write-back word on the last stored byte.
    always_ff @(posedge clk) begin
        if (!rst_n)          wb_word <= '0;
        else if (frame_done) wb_word <= {new_stat, len_out};
    end

    // Purpose: sticky flag for bytes that could not be stored.
    always_ff @(posedge clk) begin
        if (!rst_n || kill)          dropped <= 1'b0;
        else if (rx_valid && !take)  dropped <= 1'b1;
    end

    // R7
    buf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> (buf_wr_addr - base_q) < ADDR_W'(MAX_FRAME));
    // R9
    drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dropped && !kill) |=> dropped);
    // R10
    kill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !dropped && !taking);
endmodule

// File: rtl/rxr_ring_engine.sv
// Module: receive descriptor ring engine (top).
// Walks a ring of descriptors in an external memory, stores each frame in
// the buffer of an empty descriptor, writes back status and length, and
// stalls on descriptors still owned by software until cont.
// Assumes a one-cycle descriptor read latency.
module rxr_ring_engine
    import rxr_pkg::*;
#(
    parameter int IDX_W     = 4,
    parameter int ADDR_W    = 32,
    parameter int MAX_FRAME = 1518
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                kill,
    input  logic                cont,
    input  logic                rx_valid,
    input  logic [7:0]          rx_data,
    input  logic                rx_last,
    input  logic [ERR_W-1:0]    rx_err,
    output logic                dsc_rd_en,
    output logic                dsc_wr_en,
    output logic [IDX_W-1:0]    dsc_idx,
    input  logic [HALF_W-1:0]   dsc_rd_stat,
    input  logic [ADDR_W-1:0]   dsc_rd_addr,
    output logic [2*HALF_W-1:0] dsc_wr_data,
    output logic                buf_wr_en,
    output logic [ADDR_W-1:0]   buf_wr_addr,
    output logic [7:0]          buf_wr_data,
    output logic                rx_dropped
);
    rxr_state_e state;
    logic       frame_done;
    logic       desc_wrap;

    rxr_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .kill       (kill),
        .cont       (cont),
        .desc_empty (dsc_rd_stat[ST_EMPTY]),
        .frame_done (frame_done),
        .state      (state)
    );

    rxr_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .kill    (kill),
        .advance (state == RX_WBACK),
        .wrap    (desc_wrap),
        .idx     (dsc_idx)
    );

    rxr_frame_path #(.ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME)) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .kill        (kill),
        .ready       (state == RX_READY),
        .load_desc   (state == RX_CHECK),
        .desc_stat   (dsc_rd_stat),
        .desc_base   (dsc_rd_addr),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_last     (rx_last),
        .rx_err      (rx_err),
        .frame_done  (frame_done),
        .desc_wrap   (desc_wrap),
        .wb_word     (dsc_wr_data),
        .buf_wr_en   (buf_wr_en),
        .buf_wr_addr (buf_wr_addr),
        .buf_wr_data (buf_wr_data),
        .dropped     (rx_dropped)
    );

    // Purpose: memory strobes follow the sequencing state.
    assign dsc_rd_en = (state == RX_FETCH);
    assign dsc_wr_en = (state == RX_WBACK);

    // R4
    wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_wr_en |-> (!dsc_wr_data[HALF_W+ST_EMPTY] && dsc_wr_data[HALF_W+ST_LAST]));
    // R10
    kill_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !dsc_wr_en);
endmodule

// File: tb/rxr_ring_engine_bench.sv
// Bench: descriptor memory model, frame driver and a transaction-level
// reference model (queues of expected writes) compared every clock.
module rxr_ring_engine_bench;
    localparam int RING = 4;
    localparam int MAXF = 1518;
    localparam logic [15:0] EMP = 16'h8000, WRP = 16'h4000, LST = 16'h2000;
    localparam logic [15:0] LNG = 16'h0010, CLR = 16'hA01F;

    logic        clk = 1'b0, rst_n = 1'b0, kill = 1'b0, cont = 1'b0;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [3:0]  rx_err = '0;
    logic        dsc_rd_en, dsc_wr_en, buf_wr_en, rx_dropped;
    logic [3:0]  dsc_idx;
    logic [15:0] rd_stat_q = '0;
    logic [31:0] rd_addr_q = '0, dsc_wr_data, buf_wr_addr;
    logic [7:0]  buf_wr_data;

    logic [15:0] mem_stat [16];
    logic [15:0] mem_len  [16];
    logic [31:0] mem_addr [16];
    logic        sw_wr = 1'b0;
    logic [3:0]  sw_idx = '0;
    logic [15:0] sw_stat = '0;

    logic [39:0] bq[$];
    logic [35:0] wq[$];
    int  n_chk = 0, n_bad = 0, rd_count = 0, cyc = 0, ex_idx = 0;
    bit  exp_drop = 1'b0, eng_live = 1'b0;
    bit  own_empty [RING];
    logic [15:0] sw_stat_of [RING];

    always #2 clk = ~clk;

    rxr_ring_engine u_rxr_ring_engine (
        .clk(clk), .rst_n(rst_n), .kill(kill), .cont(cont),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
        .dsc_rd_en(dsc_rd_en), .dsc_wr_en(dsc_wr_en), .dsc_idx(dsc_idx),
        .dsc_rd_stat(rd_stat_q), .dsc_rd_addr(rd_addr_q), .dsc_wr_data(dsc_wr_data),
        .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
        .rx_dropped(rx_dropped)
    );

    function automatic void chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endfunction

    function automatic logic [31:0] base_of(int i);
        return 32'h2000_0000 + 32'(i) * 32'h1000;
    endfunction

    // descriptor memory: one-cycle read, engine and software writes, watchdog
    always @(posedge clk) begin
        if (dsc_rd_en) begin
            rd_stat_q <= mem_stat[dsc_idx];
            rd_addr_q <= mem_addr[dsc_idx];
        end
        if (dsc_wr_en) begin
            mem_stat[dsc_idx] <= dsc_wr_data[31:16];
            mem_len[dsc_idx]  <= dsc_wr_data[15:0];
        end
        if (sw_wr) begin
            mem_stat[sw_idx] <= sw_stat;
            mem_len[sw_idx]  <= 16'(MAXF);
            mem_addr[sw_idx] <= base_of(int'(sw_idx));
        end
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // per-clock comparison against the expected-write queues
    always @(negedge clk) begin
        logic [39:0] eb;
        logic [35:0] ew;
        if (rst_n) begin
            if (buf_wr_en) begin
                if (bq.size() == 0) chk(0, "R9", "unexpected buffer write", buf_wr_addr, 0);
                else begin
                    eb = bq.pop_front();
                    chk({buf_wr_addr, buf_wr_data} == eb, "R2/R7", "buffer write",
                        {buf_wr_addr, buf_wr_data}, eb);
                end
            end
            if (dsc_wr_en) begin
                if (wq.size() == 0) chk(0, "R10", "unexpected descriptor write", dsc_idx, 0);
                else begin
                    ew = wq.pop_front();
                    chk({dsc_idx, dsc_wr_data} == ew, "R4/R5/R6", "write-back",
                        {dsc_idx, dsc_wr_data}, ew);
                end
            end
            if (dsc_rd_en) begin
                rd_count++;
                chk(dsc_idx == 4'(ex_idx), "R3", "fetch index", dsc_idx, ex_idx);
            end
            chk(rx_dropped == exp_drop, "R9", "drop flag", rx_dropped, exp_drop);
        end
    end

    task automatic rearm(int i, logic [15:0] extra);
        @(negedge clk);
        sw_stat = EMP | (i == RING - 1 ? WRP : 16'h0) | extra;
        sw_stat_of[i] = sw_stat;
        sw_idx = 4'(i);
        sw_wr = 1'b1;
        own_empty[i] = 1'b1;
        @(negedge clk);
        sw_wr = 1'b0;
    endtask

    task automatic pulse_cont();
        @(negedge clk);
        cont = 1'b1;
        @(posedge clk);
        eng_live = 1'b1;
        @(negedge clk);
        cont = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_kill();
        @(negedge clk);
        kill = 1'b1;
        @(posedge clk);
        eng_live = 1'b0;
        ex_idx = 0;
        exp_drop = 1'b0;
        @(negedge clk);
        kill = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic send_frame(int len, logic [3:0] errs, int seed);
        bit acc;
        logic [15:0] st;
        int keep;
        acc = eng_live && own_empty[ex_idx];
        if (acc) begin
            keep = (len > MAXF) ? MAXF : len;
            for (int i = 0; i < keep; i++)
                bq.push_back({base_of(ex_idx) + 32'(i), 8'(seed * 7 + i)});
            st = (sw_stat_of[ex_idx] & ~CLR) | LST | (len > MAXF ? LNG : 16'h0) | {12'h0, errs};
            wq.push_back({4'(ex_idx), st, 16'(keep)});
            own_empty[ex_idx] = 1'b0;
            ex_idx = (ex_idx == RING - 1) ? 0 : ex_idx + 1;
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = 8'(seed * 7 + i);
            rx_last  = (i == len - 1);
            rx_err   = (i == len - 1) ? errs : 4'h0;
            @(posedge clk);
            if (i == 0 && !acc) exp_drop = 1'b1;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; rx_err = 4'h0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int snap_rd;
        logic [15:0] snap_stat, snap_len;
        for (int i = 0; i < 16; i++) begin
            mem_stat[i] = 16'h0; mem_len[i] = 16'h0; mem_addr[i] = 32'h0;
        end
        for (int i = 0; i < RING; i++) begin
            own_empty[i] = 1'b0; sw_stat_of[i] = 16'h0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        // R1: idle after reset until cont
        chk(rd_count == 0, "R1", "fetches before cont", rd_count, 0);
        chk(!dsc_rd_en && !dsc_wr_en && !buf_wr_en, "R1", "strobes idle",
            {dsc_rd_en, dsc_wr_en, buf_wr_en}, 0);
        chk(rx_dropped == 1'b0, "R1", "drop flag after reset", rx_dropped, 0);

        rearm(0, 16'h0); rearm(1, 16'h0); rearm(2, 16'h0100); rearm(3, 16'h0);
        pulse_cont();
        send_frame(64, 4'h0, 1);    // R2 R4 R6 plain frame
        send_frame(1, 4'h4, 2);     // R5 crc flag, single byte
        send_frame(100, 4'hB, 3);   // R5 mixed flags, R4 software bit kept
        send_frame(60, 4'h1, 4);    // R3 wrap descriptor
        // R8: descriptor 0 still owned by software, engine must sit still
        snap_rd = rd_count;
        repeat (20) @(negedge clk);
        chk(rd_count == snap_rd, "R8", "fetches while stalled", rd_count, snap_rd);
        send_frame(40, 4'h0, 5);    // R9 dropped
        chk(rx_dropped == 1'b1, "R9", "sticky drop after stall frame", rx_dropped, 1);
        rearm(0, 16'h0);
        pulse_cont();               // R8 re-fetch of index 0
        chk(rd_count == snap_rd + 1, "R8", "single re-fetch after cont", rd_count, snap_rd + 1);
        send_frame(1520, 4'h0, 6);  // R7 too long
        rearm(1, 16'h0);
        pulse_cont();
        send_frame(1518, 4'h2, 7);  // R7 boundary, no long flag
        snap_stat = mem_stat[0];
        snap_len  = mem_len[0];
        pulse_kill();               // R10
        chk(rx_dropped == 1'b0, "R10", "drop flag cleared by kill", rx_dropped, 0);
        send_frame(40, 4'h0, 8);    // R10 idle engine drops
        chk(mem_stat[0] == snap_stat && mem_len[0] == snap_len, "R10",
            "descriptor untouched by kill", {mem_stat[0], mem_len[0]}, {snap_stat, snap_len});
        rearm(0, 16'h0);
        pulse_cont();               // R10 restart at index 0
        send_frame(20, 4'h8, 9);
        repeat (10) @(negedge clk);
        chk(bq.size() == 0, "R2", "buffer writes outstanding", bq.size(), 0);
        chk(wq.size() == 0, "R4", "write-backs outstanding", wq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule